// File: doc/BRIEF.md
# Soft-Start Current Limit Sequencer

This block drives the peak-current limit of a boost switch while the converter powers up. After the device is enabled it outputs the lowest limit step. It then raises the limit one step at a time until it reaches the top of an eight-step scale. Each step stands for 225 mA, so the scale runs from 225 mA up to 1.8 A. A step is earned by time spent with the LEDs lit, not by wall-clock time. At full dimming duty the ramp takes its nominal length. At low duty the ramp stretches in proportion, because the output capacitor charges more slowly when the load draws current only part of the time.

The same block owns the enable and undervoltage policy. If the enable input stays low for a programmable number of cycles, the block requests shutdown and forces the limit back to its lowest code. A short low pulse on enable is ignored. An undervoltage event stops the converter at once and holds it off, even after the supply recovers, until enable has been taken low and raised again. Whenever the block leaves shutdown it starts the ramp again from the lowest step.

Top module: `softstart_seq`

## Requirements
- R1: While reset is asserted and right after reset, `shutdown` is 1, `ilim_code` is 0 and `ss_done` is 0. Whenever `shutdown` is 1, `ilim_code` is 0 and `ss_done` is 0.
- R2: In shutdown, `en`=1 with `uvlo`=0 at a clock edge clears `shutdown` on that edge, and `ilim_code` is 0. The limit is (ilim_code+1) x 225 mA.
- R3: During the ramp, `ilim_code` rises by exactly one after every STEP_TICKS clock edges that have `dim_on`=1. It never skips a value and never falls, except when the block enters shutdown.
- R4: Edges with `dim_on`=0 do not count toward a step. With a dimming duty of 1 in 4, the first step takes 4x(STEP_TICKS-1)+1 cycles. With `dim_on` held at 0, the code holds.
- R5: `ss_done` rises on the same edge on which `ilim_code` reaches NSTEPS-1 (7). Both then hold while the block stays enabled, whatever `dim_on` does.
- R6: If `en` is 0 for EN_LOW_TICKS consecutive edges while the block is active, `shutdown` rises on the last of those edges. A low pulse one edge shorter changes neither `shutdown` nor `ilim_code`.
- R7: `uvlo`=1 while the block is active raises `shutdown` on the next edge. The block then stays shut down while `en` remains 1, even after `uvlo` clears. It restarts only after `en` has been seen at 0 and then at 1.
- R8: In shutdown, `en`=1 has no effect while `uvlo`=1. The ramp starts on the first edge with `uvlo`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Device enable |
| uvlo | input | 1 | Supply undervoltage flag |
| dim_on | input | 1 | LED dimming on-time indication |
| ilim_code | output | 3 | Current-limit step code, limit = (code+1) x 225 mA |
| ss_done | output | 1 | Ramp has reached the final step |
| shutdown | output | 1 | Shutdown request, converter must not switch |

## Verification
The bench measures the exact edge on which each step lands, both at full duty and at a 1-in-4 duty. A design that counted wall-clock cycles instead of lit cycles would step four times too early under low duty. It also places an enable-low pulse exactly one cycle short of the timeout, and then one of full length. An off-by-one timer would either shut down on the short pulse or miss the long one. Finally it clears undervoltage while enable is still high. A design without a latched lockout would restart on its own at that point, and one that ignored undervoltage when leaving shutdown would start ramping into a collapsed supply.

// File: rtl/softstart_seq.sv
module softstart_seq #(
  parameter int NSTEPS       = 8,
  parameter int STEP_TICKS   = 16,
  parameter int EN_LOW_TICKS = 40,
  localparam int CODE_W      = $clog2(NSTEPS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              uvlo,
  input  logic              dim_on,
  output logic [CODE_W-1:0] ilim_code,
  output logic              ss_done,
  output logic              shutdown
);

  localparam int DW_W = $clog2(STEP_TICKS + 1);
  localparam int LW_W = $clog2(EN_LOW_TICKS + 1);
  localparam logic [DW_W-1:0]   DW_LAST  = DW_W'(STEP_TICKS - 1);
  localparam logic [LW_W-1:0]   LW_LAST  = LW_W'(EN_LOW_TICKS - 1);
  localparam logic [CODE_W-1:0] PRE_LAST = CODE_W'(NSTEPS - 2);

  typedef enum logic [1:0] {S_OFF, S_RAMP, S_DONE, S_UVL} st_t;

  st_t             st;
  logic [DW_W-1:0] dwell;
  logic [LW_W-1:0] lowcnt;

  wire active  = (st == S_RAMP) || (st == S_DONE);
  wire timeout = !en && (lowcnt == LW_LAST);
  wire advance = (st == S_RAMP) && dim_on && (dwell == DW_LAST);

  assign shutdown = !active;
  assign ss_done  = (st == S_DONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_OFF;
      ilim_code <= '0;
      dwell     <= '0;
      lowcnt    <= '0;
    end else begin
      case (st)
        S_OFF: begin
          ilim_code <= '0;
          dwell     <= '0;
          lowcnt    <= '0;
          if (en && !uvlo) st <= S_RAMP;
        end
        S_UVL: begin
          ilim_code <= '0;
          dwell     <= '0;
          lowcnt    <= '0;
          if (!en) st <= S_OFF;
        end
        default: begin
          if (uvlo || timeout) begin
            st        <= uvlo ? S_UVL : S_OFF;
            ilim_code <= '0;
            dwell     <= '0;
            lowcnt    <= '0;
          end else begin
            lowcnt <= en ? '0 : lowcnt + 1'b1;
            if (advance) begin
              dwell     <= '0;
              ilim_code <= ilim_code + 1'b1;
              if (ilim_code == PRE_LAST) st <= S_DONE;
            end else if (st == S_RAMP && dim_on) begin
              dwell <= dwell + 1'b1;
            end
          end
        end
      endcase
    end
  end

endmodule

module softstart_seq_chk #(
  parameter int CODE_W = 3,
  parameter int NSTEPS = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              en,
  input logic              uvlo,
  input logic              dim_on,
  input logic [CODE_W-1:0] ilim_code,
  input logic              ss_done,
  input logic              shutdown
);

  assert_off_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown |-> (ilim_code == '0 && !ss_done));

  assert_step_by_one_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!shutdown && !$past(shutdown) && ilim_code != $past(ilim_code))
      |-> ilim_code == $past(ilim_code) + 1'b1);

  assert_dim_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(dim_on) && !$past(shutdown) && !shutdown) |-> $stable(ilim_code));

  assert_done_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ss_done |-> (ilim_code == CODE_W'(NSTEPS - 1) && !shutdown));

  assert_uvlo_stop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (uvlo && !shutdown) |=> shutdown);

  assert_start_clean_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(shutdown) |-> ($past(en) && !$past(uvlo)));

endmodule

bind softstart_seq softstart_seq_chk #(.CODE_W(CODE_W), .NSTEPS(NSTEPS)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .uvlo(uvlo), .dim_on(dim_on),
  .ilim_code(ilim_code), .ss_done(ss_done), .shutdown(shutdown)
);

// File: tb/sim_softstart_seq.sv
module sim_softstart_seq;
  localparam int STEP = 16;
  localparam int LOWT = 40;

  logic clk = 0, rst_n = 0, en = 0, uvlo = 0, dim_on = 0;
  logic [2:0] ilim_code;
  logic ss_done, shutdown;
  int total = 0, fails = 0;

  always #2 clk = ~clk;

  softstart_seq #(.NSTEPS(8), .STEP_TICKS(STEP), .EN_LOW_TICKS(LOWT)) u0 (
    .clk(clk), .rst_n(rst_n), .en(en), .uvlo(uvlo), .dim_on(dim_on),
    .ilim_code(ilim_code), .ss_done(ss_done), .shutdown(shutdown));

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    step(2);
    chk("R1 shutdown in reset", shutdown, 1);
    chk("R1 code in reset", ilim_code, 0);
    rst_n = 1;
    step(1);
    chk("R1 shutdown after reset", shutdown, 1);
    chk("R1 done after reset", ss_done, 0);
  endtask

  task automatic t_full_ramp;
    en = 1; dim_on = 1;
    step(1);
    chk("R2 leaves shutdown", shutdown, 0);
    chk("R2 lowest step", ilim_code, 0);
    for (int k = 1; k < 8; k++) begin
      step(STEP - 1);
      chk("R3 before step", ilim_code, k - 1);
      chk("R5 not done early", ss_done, 0);
      step(1);
      chk("R3 step lands", ilim_code, k);
    end
    chk("R5 done at final", ss_done, 1);
    step(3 * STEP);
    chk("R5 holds code", ilim_code, 7);
    chk("R5 holds done", ss_done, 1);
  endtask

  task automatic t_en_glitch_and_timeout;
    dim_on = 0;
    en = 0;
    step(LOWT - 1);
    chk("R6 short pulse shutdown", shutdown, 0);
    en = 1;
    step(1);
    chk("R6 short pulse code", ilim_code, 7);
    chk("R6 short pulse done", ss_done, 1);
    en = 0;
    step(LOWT - 1);
    chk("R6 one short of timeout", shutdown, 0);
    step(1);
    chk("R6 timeout shutdown", shutdown, 1);
    chk("R6 timeout code", ilim_code, 0);
    chk("R6 timeout done", ss_done, 0);
  endtask

  task automatic t_low_duty;
    int cyc;
    en = 1;
    step(1);
    chk("R2 restart lowest", ilim_code, 0);
    chk("R2 restart active", shutdown, 0);
    cyc = 0;
    while (ilim_code == 0 && cyc < 1000) begin
      dim_on = (cyc % 4 == 0);
      step(1);
      cyc++;
    end
    chk("R4 stretched step cycles", cyc, 4 * (STEP - 1) + 1);
    dim_on = 0;
    step(100);
    chk("R4 hold without dimming", ilim_code, 1);
  endtask

  task automatic t_uvlo;
    dim_on = 1;
    step(STEP);
    chk("R3 step after stretch", ilim_code, 2);
    uvlo = 1;
    step(1);
    chk("R7 uvlo shutdown", shutdown, 1);
    chk("R7 uvlo code", ilim_code, 0);
    uvlo = 0;
    step(50);
    chk("R7 latched while en high", shutdown, 1);
    en = 0;
    step(1);
    chk("R7 still off with en low", shutdown, 1);
    en = 1;
    step(1);
    chk("R7 re-enable restarts", shutdown, 0);
    chk("R7 re-enable lowest", ilim_code, 0);
  endtask

  task automatic t_uv_block;
    uvlo = 1;
    step(1);
    uvlo = 0; en = 0;
    step(1);
    uvlo = 1; en = 1;
    step(10);
    chk("R8 en ignored under uvlo", shutdown, 1);
    uvlo = 0;
    step(1);
    chk("R8 starts once uvlo clears", shutdown, 0);
    chk("R8 lowest step", ilim_code, 0);
  endtask

  initial begin
    t_reset;
    t_full_ramp;
    t_en_glitch_and_timeout;
    t_low_duty;
    t_uvlo;
    t_uv_block;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    #400000;
    total++; fails++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule